// File: doc/BRIEF.md
# Contention-Budgeted Shared Cache Controller

This block is a set-associative cache shared by several jobs. Every request carries a job number. Each valid line remembers which job filled it. The controller counts, per job, how often that job is harmed by contention with other jobs. Each job also has a budget that a scheduler programs. While a job is under budget, all jobs are handled the same way. When its counter reaches the budget, the job becomes protected:

- Other jobs may no longer evict its lines. A request that would do so is served straight from main memory and nothing is allocated.
- When the job itself would evict one of its own lines, an unprotected foreign line in the same set is evicted instead.

Lines hold one data word each. Writes always go through to memory, and both reads and writes allocate on a miss. The controller handles one request at a time. A small readback port returns the counter of any job, so the scheduler can inspect the state of each budget.

Top module: `ctc_cache`

## Requirements
- R1: After reset, every line is invalid, every counter reads 0 and every budget is all ones, so the first access to any address is a miss.
- R2: A read returns the most recent data written to that address by any job. Every write is passed to memory. A read hit makes no memory access.
- R3: Victim selection on a miss:
  - The lowest-numbered invalid way is filled first.
  - If the set is full, the way named by that set's rotating pointer is chosen.
  - The pointer advances by one, wrapping, on every miss to the set, including refused ones.
  - A fill into an invalid way charges no job.
- R4: When a miss by job B evicts a line filled by a different job A, A's counter is charged one event (type 1). The evicted way then belongs to B.
- R5: When a job's miss evicts one of its own lines, and the set also holds a line owned by another job, that job is charged one event (type 2).
- R6: When a job's miss evicts its own line in a set where every line is its own, no counter changes.
- R7: A job is protected when its counter is greater than or equal to its budget. If a miss by another job would evict a protected job's line, the request is refused:
  - `rsp_bypass` is 1 and the request is served from memory.
  - The set's lines are left unchanged and no counter changes.
- R8: When a protected job's miss would evict its own line, the lowest-numbered way in the set that is owned by an unprotected other job is evicted instead, and that owner is charged. If no such way exists, the job's own line is evicted and the job is charged a type-2 event.
- R9: Counters saturate at their all-ones value.
- R10: A budget write sets that job's budget and clears its counter in the same step. A budget of zero protects the job immediately.
- R11: Requests are accepted only while `req_ready` is 1, and each accepted request yields exactly one single-cycle `rsp_valid` pulse. The memory request holds its address until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| req_valid | input | 1 | request present |
| req_ready | output | 1 | controller idle, request accepted |
| req_job | input | JOB_W | requesting job |
| req_addr | input | ADDR_W | word address |
| req_we | input | 1 | 1 = write |
| req_wdata | input | DATA_W | write data |
| rsp_valid | output | 1 | one-cycle completion pulse |
| rsp_rdata | output | DATA_W | read data |
| rsp_hit | output | 1 | request hit in the cache |
| rsp_bypass | output | 1 | request refused and served from memory |
| cfg_we | input | 1 | budget write strobe |
| cfg_job | input | JOB_W | job whose budget is written |
| cfg_limit | input | CNT_W | new budget |
| cnt_job | input | JOB_W | job selected for counter readback |
| cnt_value | output | CNT_W | counter of the selected job |
| mem_req | output | 1 | memory access request |
| mem_we | output | 1 | memory write |
| mem_addr | output | ADDR_W | memory address |
| mem_wdata | output | DATA_W | memory write data |
| mem_ack | input | 1 | memory access done |
| mem_rdata | input | DATA_W | memory read data |

## Verification
The bench builds the block with:

| Parameter | Value |
|---|---|
| SETS | 2 |
| WAYS | 2 |
| JOBS | 3 |
| ADDR_W | 6 |
| DATA_W | 8 |
| CNT_W | 3 |

With two ways per set, each miss to a full set alternates between the pointer's two positions. Directed sequences can therefore steer every eviction case deliberately: type-1 and type-2 charges, refusal, redirection and no-alternative self-eviction. A 3-bit counter reaches saturation within a handful of events. A long pseudo-random mix of jobs, 16 addresses and budgets of zero to four is then compared, access by access, against an arithmetic model of tags, owners, pointers and counters.

// File: rtl/ctc_pkg.sv
package ctc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOK,
        ST_MEM,
        ST_RESP
    } ctc_state_e;
endpackage

// File: rtl/ctc_victim_sel.sv
// Decides what a miss does to a set: fill a way (and whom to charge) or refuse.
module ctc_victim_sel #(
    parameter int WAYS = 4,
    parameter int JOBS = 8,
    localparam int JOB_W = $clog2(JOBS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]             valid_i,
    input  logic [WAYS-1:0][JOB_W-1:0]  own_i,
    input  logic [WAY_W-1:0]            ptr_i,
    input  logic [JOB_W-1:0]            job_i,
    input  logic [JOBS-1:0]             prot_i,
    output logic                        bypass_o,
    output logic [WAY_W-1:0]            fill_way_o,
    output logic                        charge_en_o,
    output logic [JOB_W-1:0]            charge_job_o
);
    logic             inv_found;
    logic [WAY_W-1:0] inv_way;
    logic [WAY_W-1:0] dflt_way;
    logic [JOB_W-1:0] dflt_own;
    logic             foreign;
    logic             alt_found;
    logic [WAY_W-1:0] alt_way;

    always_comb begin
        inv_found = 1'b0;
        inv_way   = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_i[w]) begin
                inv_found = 1'b1;
                inv_way   = WAY_W'(w);
            end
        end
        dflt_way = inv_found ? inv_way : ptr_i;
        dflt_own = own_i[dflt_way];

        foreign   = 1'b0;
        alt_found = 1'b0;
        alt_way   = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (own_i[w] != job_i) begin
                foreign = 1'b1;
                if (!prot_i[own_i[w]]) begin
                    alt_found = 1'b1;
                    alt_way   = WAY_W'(w);
                end
            end
        end

        bypass_o     = 1'b0;
        fill_way_o   = dflt_way;
        charge_en_o  = 1'b0;
        charge_job_o = dflt_own;
        if (!inv_found) begin
            if (dflt_own != job_i) begin
                if (prot_i[dflt_own]) begin
                    bypass_o = 1'b1;
                end else begin
                    charge_en_o = 1'b1;
                end
            end else if (foreign) begin
                charge_en_o = 1'b1;
                if (prot_i[job_i] && alt_found) begin
                    fill_way_o   = alt_way;
                    charge_job_o = own_i[alt_way];
                end else begin
                    charge_job_o = job_i;
                end
            end
        end
    end
endmodule

// File: rtl/ctc_budget.sv
// Per-job contention counters and budgets.
module ctc_budget #(
    parameter int JOBS  = 8,
    parameter int CNT_W = 6,
    localparam int JOB_W = $clog2(JOBS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [JOB_W-1:0] cfg_job,
    input  logic [CNT_W-1:0] cfg_limit,
    input  logic             inc_en,
    input  logic [JOB_W-1:0] inc_job,
    input  logic [JOB_W-1:0] rd_job,
    output logic [CNT_W-1:0] rd_cnt,
    output logic [JOBS-1:0]  prot_o
);
    typedef struct packed {
        logic [JOBS-1:0][CNT_W-1:0] cnt;
        logic [JOBS-1:0][CNT_W-1:0] lim;
    } budget_t;

    budget_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (inc_en && (b_q.cnt[inc_job] != '1)) begin
            b_d.cnt[inc_job] = b_q.cnt[inc_job] + CNT_W'(1);
        end
        if (cfg_we) begin
            b_d.lim[cfg_job] = cfg_limit;
            b_d.cnt[cfg_job] = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q.cnt <= '0;
            b_q.lim <= '1;
        end else begin
            b_q <= b_d;
        end
    end

    assign rd_cnt = b_q.cnt[rd_job];

    for (genvar j = 0; j < JOBS; j++) begin : g_job
        assign prot_o[j] = (b_q.cnt[j] >= b_q.lim[j]);

        a_r10_clear_on_cfg: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && cfg_job == JOB_W'(j)) |=> (b_q.cnt[j] == '0));

        a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
            (b_q.cnt[j] == '1 && !(cfg_we && cfg_job == JOB_W'(j))) |=> (b_q.cnt[j] == '1));

        a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
            !(cfg_we && cfg_job == JOB_W'(j)) |=>
                (b_q.cnt[j] == $past(b_q.cnt[j]) || b_q.cnt[j] == $past(b_q.cnt[j]) + CNT_W'(1)));
    end
endmodule

// File: rtl/ctc_line_store.sv
// Tags, owners, valid bits, data words and rotating pointers of every set.
module ctc_line_store #(
    parameter int SETS   = 16,
    parameter int WAYS   = 4,
    parameter int JOB_W  = 3,
    parameter int TAG_W  = 8,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [IDX_W-1:0]            set_sel,
    output logic [WAYS-1:0]             rd_valid,
    output logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
    output logic [WAYS-1:0][JOB_W-1:0]  rd_own,
    output logic [WAYS-1:0][DATA_W-1:0] rd_data,
    output logic [WAY_W-1:0]            rd_ptr,
    input  logic                        adv_en,
    input  logic                        meta_we,
    input  logic [WAY_W-1:0]            meta_way,
    input  logic [TAG_W-1:0]            meta_tag,
    input  logic [JOB_W-1:0]            meta_own,
    input  logic                        data_we,
    input  logic [WAY_W-1:0]            data_way,
    input  logic [DATA_W-1:0]           data_in
);
    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0]             valid;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag;
        logic [SETS-1:0][WAYS-1:0][JOB_W-1:0]  own;
        logic [SETS-1:0][WAYS-1:0][DATA_W-1:0] data;
        logic [SETS-1:0][WAY_W-1:0]            ptr;
    } store_t;

    store_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (adv_en) begin
            s_d.ptr[set_sel] = (s_q.ptr[set_sel] == WAY_W'(WAYS - 1)) ? '0
                             : s_q.ptr[set_sel] + WAY_W'(1);
        end
        if (meta_we) begin
            s_d.valid[set_sel][meta_way] = 1'b1;
            s_d.tag[set_sel][meta_way]   = meta_tag;
            s_d.own[set_sel][meta_way]   = meta_own;
        end
        if (data_we) begin
            s_d.data[set_sel][data_way] = data_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_valid = s_q.valid[set_sel];
    assign rd_tag   = s_q.tag[set_sel];
    assign rd_own   = s_q.own[set_sel];
    assign rd_data  = s_q.data[set_sel];
    assign rd_ptr   = s_q.ptr[set_sel];
endmodule

// File: rtl/ctc_cache.sv
// Shared cache controller with per-job contention budgets.
module ctc_cache #(
    parameter int SETS   = 16,
    parameter int WAYS   = 4,
    parameter int JOBS   = 8,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 6,
    localparam int JOB_W = $clog2(JOBS),
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS),
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [JOB_W-1:0]  req_job,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_we,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_hit,
    output logic              rsp_bypass,
    input  logic              cfg_we,
    input  logic [JOB_W-1:0]  cfg_job,
    input  logic [CNT_W-1:0]  cfg_limit,
    input  logic [JOB_W-1:0]  cnt_job,
    output logic [CNT_W-1:0]  cnt_value,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    import ctc_pkg::*;

    typedef struct packed {
        ctc_state_e        st;
        logic [JOB_W-1:0]  job;
        logic [ADDR_W-1:0] addr;
        logic              we;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              hit;
        logic              bypass;
        logic              fill;
        logic [WAY_W-1:0]  way;
    } ctl_t;

    ctl_t r_d, r_q;

    logic [IDX_W-1:0]            set_idx;
    logic [TAG_W-1:0]            req_tag;
    logic [WAYS-1:0]             rd_valid;
    logic [WAYS-1:0][TAG_W-1:0]  rd_tag;
    logic [WAYS-1:0][JOB_W-1:0]  rd_own;
    logic [WAYS-1:0][DATA_W-1:0] rd_data;
    logic [WAY_W-1:0]            rd_ptr;
    logic                        hit;
    logic [WAY_W-1:0]            hit_way;
    logic                        adv_en, meta_we, data_we;
    logic [WAY_W-1:0]            data_way;
    logic [DATA_W-1:0]           data_in;
    logic                        inc_en;
    logic [JOBS-1:0]             prot;
    logic                        sel_bypass, sel_charge_en;
    logic [WAY_W-1:0]            sel_fill_way;
    logic [JOB_W-1:0]            sel_charge_job;

    assign set_idx = r_q.addr[IDX_W-1:0];
    assign req_tag = r_q.addr[ADDR_W-1:IDX_W];

    always_comb begin
        hit     = 1'b0;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (rd_valid[w] && rd_tag[w] == req_tag) begin
                hit     = 1'b1;
                hit_way = WAY_W'(w);
            end
        end
    end

    ctc_line_store #(
        .SETS(SETS), .WAYS(WAYS), .JOB_W(JOB_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) i_store (
        .clk(clk), .rst_n(rst_n), .set_sel(set_idx),
        .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_own(rd_own), .rd_data(rd_data), .rd_ptr(rd_ptr),
        .adv_en(adv_en), .meta_we(meta_we), .meta_way(sel_fill_way), .meta_tag(req_tag),
        .meta_own(r_q.job), .data_we(data_we), .data_way(data_way), .data_in(data_in)
    );

    ctc_victim_sel #(.WAYS(WAYS), .JOBS(JOBS)) i_victim (
        .valid_i(rd_valid), .own_i(rd_own), .ptr_i(rd_ptr), .job_i(r_q.job), .prot_i(prot),
        .bypass_o(sel_bypass), .fill_way_o(sel_fill_way),
        .charge_en_o(sel_charge_en), .charge_job_o(sel_charge_job)
    );

    ctc_budget #(.JOBS(JOBS), .CNT_W(CNT_W)) i_budget (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_job(cfg_job), .cfg_limit(cfg_limit),
        .inc_en(inc_en), .inc_job(sel_charge_job), .rd_job(cnt_job), .rd_cnt(cnt_value),
        .prot_o(prot)
    );

    always_comb begin
        r_d      = r_q;
        adv_en   = 1'b0;
        meta_we  = 1'b0;
        data_we  = 1'b0;
        data_way = r_q.way;
        data_in  = r_q.wdata;
        inc_en   = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st     = ST_LOOK;
                    r_d.job    = req_job;
                    r_d.addr   = req_addr;
                    r_d.we     = req_we;
                    r_d.wdata  = req_wdata;
                    r_d.hit    = 1'b0;
                    r_d.bypass = 1'b0;
                    r_d.fill   = 1'b0;
                end
            end
            ST_LOOK: begin
                if (hit) begin
                    r_d.hit = 1'b1;
                    r_d.way = hit_way;
                    if (r_q.we) begin
                        data_we  = 1'b1;
                        data_way = hit_way;
                        r_d.st   = ST_MEM;
                    end else begin
                        r_d.rdata = rd_data[hit_way];
                        r_d.st    = ST_RESP;
                    end
                end else begin
                    adv_en = 1'b1;
                    r_d.st = ST_MEM;
                    if (sel_bypass) begin
                        r_d.bypass = 1'b1;
                    end else begin
                        r_d.fill = 1'b1;
                        r_d.way  = sel_fill_way;
                        meta_we  = 1'b1;
                        inc_en   = sel_charge_en;
                        if (r_q.we) begin
                            data_we  = 1'b1;
                            data_way = sel_fill_way;
                        end
                    end
                end
            end
            ST_MEM: begin
                if (mem_ack) begin
                    r_d.st = ST_RESP;
                    if (!r_q.we) begin
                        r_d.rdata = mem_rdata;
                        if (r_q.fill) begin
                            data_we = 1'b1;
                            data_in = mem_rdata;
                        end
                    end
                end
            end
            ST_RESP: r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready  = (r_q.st == ST_IDLE);
    assign rsp_valid  = (r_q.st == ST_RESP);
    assign rsp_rdata  = r_q.rdata;
    assign rsp_hit    = r_q.hit;
    assign rsp_bypass = r_q.bypass;
    assign mem_req    = (r_q.st == ST_MEM);
    assign mem_we     = r_q.we;
    assign mem_addr   = r_q.addr;
    assign mem_wdata  = r_q.wdata;

    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r11_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    a_r2_read_hit_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_LOOK && hit && !r_q.we) |=> !mem_req);

    a_r7_refuse_keeps_set: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_LOOK && !hit && sel_bypass) |=> ($stable(rd_valid) && $stable(rd_tag)));

    a_r4_new_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_LOOK && !hit && !sel_bypass) |=>
            (rd_own[$past(sel_fill_way)] == $past(r_q.job) && rd_valid[$past(sel_fill_way)]));
endmodule

// File: tb/test_ctc_cache.sv
module test_ctc_cache;
    localparam int SETS = 2, WAYS = 2, JOBS = 3, ADDR_W = 6, DATA_W = 8, CNT_W = 3;
    localparam int CMAX = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic              req_valid = 1'b0, req_ready, req_we = 1'b0;
    logic [1:0]        req_job = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              rsp_valid, rsp_hit, rsp_bypass;
    logic [DATA_W-1:0] rsp_rdata;
    logic              cfg_we = 1'b0;
    logic [1:0]        cfg_job = '0, cnt_job = '0;
    logic [CNT_W-1:0]  cfg_limit = '0, cnt_value;
    logic              mem_req, mem_we;
    logic              mem_ack = 1'b0;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata = '0;

    ctc_cache #(.SETS(SETS), .WAYS(WAYS), .JOBS(JOBS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W))
    i_ctc_cache (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_job(req_job),
        .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_hit(rsp_hit), .rsp_bypass(rsp_bypass), .cfg_we(cfg_we),
        .cfg_job(cfg_job), .cfg_limit(cfg_limit), .cnt_job(cnt_job), .cnt_value(cnt_value),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    logic [DATA_W-1:0] mem_arr [64];
    int ref_mem [64];

    always @(posedge clk) begin
        if (mem_req && !mem_ack) begin
            mem_ack   <= 1'b1;
            mem_rdata <= mem_arr[mem_addr];
            if (mem_we) mem_arr[mem_addr] <= mem_wdata;
        end else begin
            mem_ack <= 1'b0;
        end
    end

    int total = 0, bad = 0;
    bit done = 1'b0;

    int m_valid [SETS][WAYS];
    int m_tag   [SETS][WAYS];
    int m_own   [SETS][WAYS];
    int m_ptr   [SETS];
    int m_cnt   [JOBS];
    int m_lim   [JOBS];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic bit prot(input int j);
        return m_cnt[j] >= m_lim[j];
    endfunction

    task automatic charge(input int j);
        if (m_cnt[j] < CMAX) m_cnt[j]++;
    endtask

    task automatic model_access(input int job, input int addr, output bit hit, output bit byp);
        int s, t, dv, own, inv, alt;
        bit others;
        s = addr % SETS; t = addr / SETS;
        hit = 1'b0; byp = 1'b0;
        for (int w = 0; w < WAYS; w++) if (m_valid[s][w] != 0 && m_tag[s][w] == t) hit = 1'b1;
        if (hit) return;
        inv = -1;
        for (int w = WAYS - 1; w >= 0; w--) if (m_valid[s][w] == 0) inv = w;
        dv = m_ptr[s];
        m_ptr[s] = (m_ptr[s] + 1) % WAYS;
        if (inv >= 0) begin
            dv = inv;
        end else begin
            own = m_own[s][dv];
            others = 1'b0; alt = -1;
            for (int w = WAYS - 1; w >= 0; w--)
                if (m_own[s][w] != job) begin
                    others = 1'b1;
                    if (!prot(m_own[s][w])) alt = w;
                end
            if (own != job) begin
                if (prot(own)) begin byp = 1'b1; return; end
                charge(own);
            end else if (others) begin
                if (prot(job) && alt >= 0) begin
                    dv = alt;
                    charge(m_own[s][alt]);
                end else begin
                    charge(job);
                end
            end
        end
        m_valid[s][dv] = 1; m_tag[s][dv] = t; m_own[s][dv] = job;
    endtask

    task automatic get_cnt(input int j, output int v);
        @(negedge clk);
        cnt_job = 2'(j);
        #1;
        v = int'(cnt_value);
    endtask

    task automatic check_cnts(input string tag);
        int v;
        for (int j = 0; j < JOBS; j++) begin
            get_cnt(j, v);
            chk(v == m_cnt[j], tag, v, m_cnt[j]);
        end
    endtask

    task automatic set_limit(input int j, input int lim);
        @(negedge clk);
        cfg_we = 1'b1; cfg_job = 2'(j); cfg_limit = 3'(lim);
        @(negedge clk);
        cfg_we = 1'b0;
        m_lim[j] = lim; m_cnt[j] = 0;
    endtask

    // Issues one request, compares hit/bypass/data against the model and counts response pulses.
    task automatic access(input int job, input int addr, input bit we, input int wd,
                          input string tag, output bit got_hit, output bit got_byp);
        bit eh, eb;
        int pulses, exp_rd;
        logic [DATA_W-1:0] cap;
        exp_rd = ref_mem[addr];
        model_access(job, addr, eh, eb);
        if (we) ref_mem[addr] = wd;
        @(negedge clk);
        req_valid = 1'b1; req_job = 2'(job); req_addr = 6'(addr); req_we = we; req_wdata = 8'(wd);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        pulses = 0; cap = '0; got_hit = 1'b0; got_byp = 1'b0;
        for (int c = 0; c < 10; c++) begin
            if (rsp_valid) begin
                pulses++;
                cap = rsp_rdata; got_hit = rsp_hit; got_byp = rsp_bypass;
            end
            @(negedge clk);
        end
        chk(pulses == 1, "R11 response pulses", pulses, 1);
        chk(req_ready == 1'b1, "R11 ready after response", int'(req_ready), 1);
        chk(got_hit == eh, {tag, " hit"}, int'(got_hit), int'(eh));
        chk(got_byp == eb, {"R7 bypass ", tag}, int'(got_byp), int'(eb));
        if (!we) chk(int'(cap) == exp_rd, "R2 read data", int'(cap), exp_rd);
        else     chk(int'(mem_arr[addr]) == wd, "R2 write-through", int'(mem_arr[addr]), wd);
    endtask

    function automatic int ad(input int tag, input int set);
        return tag * SETS + set;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit h, b;
        int v;
        logic [15:0] lfsr;
        for (int a = 0; a < 64; a++) begin
            mem_arr[a] = 8'((a * 37 + 5) & 8'hff);
            ref_mem[a] = (a * 37 + 5) & 255;
        end
        for (int s = 0; s < SETS; s++) begin
            m_ptr[s] = 0;
            for (int w = 0; w < WAYS; w++) begin
                m_valid[s][w] = 0; m_tag[s][w] = 0; m_own[s][w] = 0;
            end
        end
        for (int j = 0; j < JOBS; j++) begin m_cnt[j] = 0; m_lim[j] = CMAX; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
        check_cnts("R1 counters after reset");
        access(0, ad(1, 0), 1'b0, 0, "R1 cold miss", h, b);
        chk(h == 1'b0, "R1 first access misses", int'(h), 0);

        // R2: hits and write-through
        access(0, ad(1, 0), 1'b0, 0, "R2 read hit", h, b);
        chk(h == 1'b1, "R2 repeat read hits", int'(h), 1);
        access(0, ad(1, 0), 1'b1, 8'h5a, "R2 write hit", h, b);
        access(1, ad(1, 0), 1'b0, 0, "R2 other job reads", h, b);

        // R3: second invalid way filled without charge
        access(0, ad(2, 0), 1'b0, 0, "R3 fill invalid way", h, b);
        check_cnts("R3 no charge on invalid fill");

        // R6: full set, all own lines
        access(0, ad(3, 0), 1'b0, 0, "R6 self eviction", h, b);
        get_cnt(0, v); chk(v == 0, "R6 no self charge", v, 0);

        // R4: job 1 evicts job 0's line
        access(1, ad(4, 0), 1'b0, 0, "R4 foreign eviction", h, b);
        get_cnt(0, v); chk(v == 1, "R4 type-1 charge", v, 1);

        // R5: job 0 evicts own line while job 1 shares the set
        access(0, ad(5, 0), 1'b0, 0, "R5 own eviction in shared set", h, b);
        get_cnt(0, v); chk(v == 2, "R5 type-2 charge", v, 2);

        // R10: budget write clears counter, zero budget protects
        set_limit(0, 0);
        get_cnt(0, v); chk(v == 0, "R10 clear on budget write", v, 0);
        access(1, ad(6, 0), 1'b0, 0, "R5 job 1 own eviction", h, b);
        access(1, ad(7, 0), 1'b0, 0, "R7 refused", h, b);
        chk(b == 1'b1, "R7 refused access bypasses", int'(b), 1);
        check_cnts("R7 no counter change");
        access(0, ad(5, 0), 1'b0, 0, "R7 protected line kept", h, b);
        chk(h == 1'b1, "R7 protected line still hits", int'(h), 1);

        // R8: protected job redirects eviction to foreign unprotected line
        access(2, ad(8, 0), 1'b0, 0, "R4 job 2 evicts job 1", h, b);
        access(0, ad(9, 0), 1'b0, 0, "R8 redirected eviction", h, b);
        get_cnt(2, v); chk(v == 1, "R8 foreign owner charged", v, 1);
        get_cnt(0, v); chk(v == 0, "R8 protected job not charged", v, 0);
        access(0, ad(5, 0), 1'b0, 0, "R8 own line kept", h, b);
        chk(h == 1'b1, "R8 own line still hits", int'(h), 1);
        check_cnts("R8 counters");

        // R9: saturation via repeated type-2 charges with no alternative
        set_limit(1, 0);
        set_limit(2, 0);
        access(1, ad(1, 1), 1'b0, 0, "R9 setup", h, b);
        access(2, ad(2, 1), 1'b0, 0, "R9 setup", h, b);
        for (int k = 0; k < 16; k++) access(1, ad(3 + k, 1), 1'b0, 0, "R9 pressure", h, b);
        get_cnt(1, v); chk(v == CMAX, "R9 counter saturates", v, CMAX);
        check_cnts("R9 counters");

        // Sweep: pseudo-random jobs, addresses, writes and budgets
        lfsr = 16'hace1;
        for (int n = 0; n < 600; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (n % 25 == 0) set_limit(int'(lfsr[1:0]) % JOBS, int'(lfsr[6:4]) % 5);
            access(int'(lfsr[9:8]) % JOBS, int'(lfsr[3:0]), lfsr[11] & lfsr[12],
                   int'(lfsr[15:8]), "R3 sweep", h, b);
            if (n % 10 == 0) check_cnts("R4 sweep counters");
        end
        check_cnts("R5 sweep final counters");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule